// File: doc/BRIEF.md
# Nested Loop Index Generator

This block steps the index tuple of a perfect loop nest with no overhead cycles between iterations. The control side loads a packed vector of inclusive upper bounds and a common stride. The datapath that does the inner-loop work then raises a one-cycle done strobe each time it finishes an iteration. On every such strobe the block moves the packed index vector to the next tuple of the nest. When the innermost loop is exhausted, it carries into the nearest enclosing loop that still has room. If several consecutive loops are all at their last iteration, it crosses all of them in that same cycle.

When every loop is exhausted, the indices return to zero and a registered end-of-nest flag rises. The flag stays up until the controller sends a restart pulse or pauses the unit by dropping its enable. While the unit is paused it holds its indices and ignores the done strobe. One restart pulse followed by consecutive strobes walks the whole nest once.

Top module: `nest_index_gen`

## Requirements
- R1: After reset every index field is zero and the end-of-nest flag is low.
- R2: Loop k (0 = outermost) occupies bits (k+1)*IDX_W-1 down to k*IDX_W of both the index and bound vectors, so the innermost loop sits in the most significant field.
- R3: The index vector changes only on a clock edge where the step strobe and the enable are both high, or where restart is high; otherwise it holds.
- R4: On a step, the innermost loop whose index is strictly below its bound is advanced by the stride, with the sum taken modulo 2^IDX_W.
- R5: Every loop nested inside the advanced loop returns to zero in that same cycle, so several exhausted levels are crossed in one step.
- R6: Bounds are inclusive: when the stride is 1, a loop's index takes every value from zero up to and including its bound.
- R7: A step while no loop is below its bound clears the whole index vector, and the end-of-nest flag is high after that edge; the flag rises exactly once per complete pass.
- R8: Once high, the end-of-nest flag stays high until a restart pulse, or until an edge where the enable is low, which clears it.
- R9: While the enable is low, the step strobe has no effect on the indices.
- R10: A restart pulse clears all indices and the end-of-nest flag on the next edge, and it takes priority over a simultaneous step.
- R11: A loop with bound zero contributes exactly one iteration (index 0) per visit of its parent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Unit running; low pauses the unit and clears the end flag |
| restart_i | input | 1 | Clears indices and end flag |
| step_i | input | 1 | Inner-loop iteration finished |
| stride_i | input | IDX_W | Increment applied to the advancing loop |
| bounds_i | input | NEST*IDX_W | Packed inclusive upper bounds, innermost in the top field |
| index_o | output | NEST*IDX_W | Packed current index tuple |
| nest_done_o | output | 1 | Whole nest has completed |

## Verification
Assertions check on every cycle the following: the priority selector never advances more than one loop, and it never both advances and clears the same loop. Indices stay still without a step. Restart clears the unit, the end flag stays sticky, and the flag rises only out of a step that lands on an all-zero vector. The tuple order itself can only be shown by the bench's scenarios. Those scenarios cover multi-level carries in one cycle, inclusive bounds, zero bounds, strides above one and modulo wrap. Each pass is compared against nested software loops, and the bench confirms a single end flag per pass.

// File: rtl/nig_pkg.sv
package nig_pkg;
    // Action the unit takes on the coming clock edge
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_STEP  = 3'd1,
        OP_WRAP  = 3'd2,
        OP_CLEAR = 3'd3,
        OP_PAUSE = 3'd4
    } nig_op_e;
endpackage

// File: rtl/nig_lane.sv
// One loop level: compares the index with its bound and forms the candidate next value.
module nig_lane #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [IDX_W-1:0] bound_i,
    input  logic [IDX_W-1:0] stride_i,
    input  logic             adv_i,
    input  logic             clr_i,
    output logic             below_o,
    output logic [IDX_W-1:0] nxt_o
);
    always_comb begin
        below_o = idx_i < bound_i;
        if (adv_i)
            nxt_o = idx_i + stride_i;
        else if (clr_i)
            nxt_o = '0;
        else
            nxt_o = idx_i;
    end
endmodule

// File: rtl/nig_select.sv
// Priority selector: innermost level still below its bound advances; all levels inside it clear.
module nig_select #(
    parameter int NEST = 3
) (
    input  logic [NEST-1:0] below_i,
    output logic [NEST-1:0] adv_o,
    output logic [NEST-1:0] clr_o,
    output logic            exhausted_o
);
    logic found;

    always_comb begin
        adv_o = '0;
        clr_o = '0;
        found = 1'b0;
        for (int k = NEST - 1; k >= 0; k--) begin
            if (!found && below_i[k]) begin
                adv_o[k] = 1'b1;
                found    = 1'b1;
            end else if (!found) begin
                clr_o[k] = 1'b1;
            end
        end
        exhausted_o = !found;
    end

    // R4: at most one loop advances per step
    always_comb begin
        a_r4_single_advance: assert ($onehot0(adv_o));
    end
    // R5: a loop is never both advanced and cleared
    always_comb begin
        a_r5_adv_clr_disjoint: assert ((adv_o & clr_o) == '0);
    end
endmodule

// File: rtl/nest_index_gen.sv
module nest_index_gen #(
    parameter int NEST  = 3,
    parameter int IDX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable_i,
    input  logic                  restart_i,
    input  logic                  step_i,
    input  logic [IDX_W-1:0]      stride_i,
    input  logic [NEST*IDX_W-1:0] bounds_i,
    output logic [NEST*IDX_W-1:0] index_o,
    output logic                  nest_done_o
);
    import nig_pkg::*;

    localparam int VEC_W = NEST * IDX_W;

    typedef struct packed {
        logic [VEC_W-1:0] idx;
        logic             done;
    } state_t;

    state_t state_d, state_q;
    nig_op_e op;

    logic [NEST-1:0]  below, adv, clr;
    logic             exhausted;
    logic [VEC_W-1:0] lane_nxt;

    // One lane per loop level; level k lives in field k (k = 0 outermost)
    for (genvar k = 0; k < NEST; k++) begin : g_lane
        nig_lane #(.IDX_W(IDX_W)) i_lane (
            .idx_i    (state_q.idx[k*IDX_W +: IDX_W]),
            .bound_i  (bounds_i[k*IDX_W +: IDX_W]),
            .stride_i (stride_i),
            .adv_i    (adv[k]),
            .clr_i    (clr[k]),
            .below_o  (below[k]),
            .nxt_o    (lane_nxt[k*IDX_W +: IDX_W])
        );
    end

    nig_select #(.NEST(NEST)) i_select (
        .below_i     (below),
        .adv_o       (adv),
        .clr_o       (clr),
        .exhausted_o (exhausted)
    );

    always_comb begin
        if (restart_i)
            op = OP_CLEAR;
        else if (!enable_i)
            op = OP_PAUSE;
        else if (step_i)
            op = exhausted ? OP_WRAP : OP_STEP;
        else
            op = OP_HOLD;

        state_d = state_q;
        unique case (op)
            OP_CLEAR: begin
                state_d.idx  = '0;
                state_d.done = 1'b0;
            end
            OP_PAUSE: state_d.done = 1'b0;
            OP_STEP:  state_d.idx  = lane_nxt;
            OP_WRAP: begin
                state_d.idx  = '0;
                state_d.done = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign index_o     = state_q.idx;
    assign nest_done_o = state_q.done;

    // R3: indices hold without an enabled step or a restart
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !(step_i && enable_i)) |=> $stable(index_o));
    // R10: restart clears everything
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (index_o == '0) && !nest_done_o);
    // R8: end flag is sticky while running
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_done_o && enable_i && !restart_i) |=> nest_done_o);
    // R8: pausing clears the end flag
    a_r8_pause_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i) |=> !nest_done_o);
    // R7: end flag rises only from an enabled step and leaves a zero vector
    a_r7_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nest_done_o) |-> ($past(step_i && enable_i && !restart_i) && index_o == '0));
endmodule

// File: tb/test_nest_index_gen.sv
`timescale 1ns/1ps
module test_nest_index_gen;
    localparam int NEST = 3;
    localparam int W    = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable_i = 1'b0;
    logic            restart_i = 1'b0;
    logic            step_i = 1'b0;
    logic [W-1:0]    stride_i = 8'd1;
    logic [NEST*W-1:0] bounds_i = '0;
    logic [NEST*W-1:0] index_o;
    logic            nest_done_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nest_index_gen #(.NEST(NEST), .IDX_W(W)) i_nest_index_gen (
        .clk, .rst_n, .enable_i, .restart_i, .step_i,
        .stride_i, .bounds_i, .index_o, .nest_done_o
    );

    // Each entry: {outer bound, middle bound, inner bound, stride}
    localparam logic [31:0] VECS [6] = '{
        {8'd2, 8'd1, 8'd3, 8'd1},
        {8'd0, 8'd0, 8'd0, 8'd1},
        {8'd0, 8'd2, 8'd0, 8'd1},
        {8'd3, 8'd0, 8'd2, 8'd1},
        {8'd4, 8'd2, 8'd5, 8'd2},
        {8'd1, 8'd3, 8'd1, 8'd3}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_restart();
        restart_i = 1'b1;
        tick();
        restart_i = 1'b0;
    endtask

    int  rises;
    int  visits;
    logic prev_done;

    task automatic visit(logic [7:0] a, logic [7:0] b, logic [7:0] c);
        chk("R2 R4 R5 R6 R11 tuple", 32'(index_o), 32'({c, b, a}));
        chk("R7 no early end flag", 32'(nest_done_o), 32'd0);
        visits++;
        step_i = 1'b1;
        tick();
        step_i = 1'b0;
        if (nest_done_o && !prev_done) rises++;
        prev_done = nest_done_o;
    endtask

    task automatic run_pass(logic [7:0] ba, logic [7:0] bb, logic [7:0] bc, logic [7:0] s);
        logic [7:0] a, b, c;
        bounds_i = {bc, bb, ba};
        stride_i = s;
        do_restart();
        rises = 0; visits = 0; prev_done = nest_done_o;
        a = 0;
        forever begin
            b = 0;
            forever begin
                c = 0;
                forever begin
                    visit(a, b, c);
                    if (c < bc) c = c + s; else break;
                end
                if (b < bb) b = b + s; else break;
            end
            if (a < ba) a = a + s; else break;
        end
        chk("R7 cleared after pass", 32'(index_o), 32'd0);
        chk("R7 end flag high", 32'(nest_done_o), 32'd1);
        chk("R7 one end flag per pass", rises, 32'd1);
        if (s == 8'd1)
            chk("R6 visit count", visits, (ba + 1) * (bb + 1) * (bc + 1));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 index after reset", 32'(index_o), 32'd0);
        chk("R1 end flag after reset", 32'(nest_done_o), 32'd0);
        rst_n = 1'b1;
        enable_i = 1'b1;
        tick();

        for (int v = 0; v < 6; v++)
            run_pass(VECS[v][31:24], VECS[v][23:16], VECS[v][15:8], VECS[v][7:0]);

        // R8: end flag stays high while idle, then enable low clears it
        repeat (3) tick();
        chk("R8 end flag sticky", 32'(nest_done_o), 32'd1);
        enable_i = 1'b0;
        tick();
        chk("R8 pause clears end flag", 32'(nest_done_o), 32'd0);
        enable_i = 1'b1;

        // R2 R3: one step lands in the top field, then holds without steps
        bounds_i = {8'd5, 8'd5, 8'd5};
        stride_i = 8'd1;
        do_restart();
        step_i = 1'b1; tick(); step_i = 1'b0;
        chk("R2 innermost in top field", 32'(index_o), 32'h010000);
        repeat (3) tick();
        chk("R3 hold without step", 32'(index_o), 32'h010000);

        // R9: step ignored while enable low
        enable_i = 1'b0;
        step_i = 1'b1;
        repeat (2) tick();
        step_i = 1'b0;
        chk("R9 step ignored when paused", 32'(index_o), 32'h010000);
        enable_i = 1'b1;

        // R10: restart wins over a simultaneous step
        restart_i = 1'b1; step_i = 1'b1;
        tick();
        restart_i = 1'b0; step_i = 1'b0;
        chk("R10 restart clears index", 32'(index_o), 32'd0);
        chk("R10 restart clears end flag", 32'(nest_done_o), 32'd0);

        // R4: stride sum wraps modulo 256 (0 -> 200 -> 144)
        bounds_i = {8'd255, 8'd0, 8'd0};
        stride_i = 8'd200;
        do_restart();
        step_i = 1'b1; tick();
        chk("R4 stride add", 32'(index_o), 32'hC80000);
        tick(); step_i = 1'b0;
        chk("R4 modulo wrap", 32'(index_o), 32'h900000);

        // R10: restart after a completed pass clears the end flag
        bounds_i = '0;
        stride_i = 8'd1;
        do_restart();
        step_i = 1'b1; tick(); step_i = 1'b0;
        chk("R7 R11 single-tuple nest ends", 32'(nest_done_o), 32'd1);
        do_restart();
        chk("R10 restart drops end flag", 32'(nest_done_o), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule